// File: doc/BRIEF.md
# Fused ReLU and 2x2 Max-Pool Streaming Stage

This block sits directly behind a convolution engine and turns its output stream into a pooled feature map. The incoming stream carries one pixel per beat in raster order: row by row, left to right. Each beat holds the results for all output channels side by side. Every channel value is first rectified, so a negative value becomes zero. The rectified values are then reduced to one maximum per non-overlapping 2x2 window. Only the pooled pixels leave the block, so the full-resolution map never has to be written out and read back.

The frame size is given at run time on two inputs, up to the limits set by parameters. The pooled map is half as wide and half as tall as the input, and the channel count stays the same. When the width or the height is odd, the trailing column or row has no partner and is consumed without producing output. Both streams use a valid/ready handshake. A stalled consumer holds back the producer without any result being lost.

Top module: `relu_maxpool2x2`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: Each channel value is rectified before pooling. A negative input (two's complement, DATA_W bits) counts as 0, so a window whose values are all negative yields 0, and no output channel is ever negative.
- R3: Each output channel c, at bits [c*DATA_W +: DATA_W] of outData, equals the maximum of the rectified channel-c values of its 2x2 window. The same packing applies to inData. Channels do not interact.
- R4: A frame of W x H input pixels produces exactly floor(W/2)*floor(H/2) outputs, in raster order of the pooled map, and nothing more.
- R5: When W is odd, the last input column of every row is accepted and does not affect any output.
- R6: When H is odd, the last input row is accepted and does not affect any output.
- R7: While outValid is 1 and outReady is 0, outValid stays 1 and outData stays unchanged until the transfer completes. No result is lost or duplicated.
- R8: inReady is 0 only while a result is waiting and outReady is 0. With outReady held at 1, one input pixel is accepted every cycle.
- R9: The pooled result appears on outData, with outValid at 1, in the cycle right after the window's bottom-right pixel is accepted.
- R10: Frames follow one another with no reset in between. The position counters wrap after the last pixel of a frame, and values left in the row store from an earlier frame do not affect a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frameWidth | input | $clog2(MAX_W+1) | Input frame width in pixels, held stable during a frame |
| frameHeight | input | $clog2(MAX_H+1) | Input frame height in pixels, held stable during a frame |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Stage can take the input pixel |
| inData | input | CHANNELS*DATA_W | Signed channel values of one pixel |
| outValid | output | 1 | Pooled pixel present |
| outReady | input | 1 | Consumer takes the pooled pixel |
| outData | output | CHANNELS*DATA_W | Pooled channel values |

## Verification
The assertions take for granted that the frame dimensions are at least 1 and within the parameter limits. They also assume that the dimensions change only between frames, and that the consumer eventually raises outReady. The bench changes frameWidth and frameHeight only after all outputs of the previous frame have drained. Its sweep covers even and odd sizes from 1 to the full row-store width. Input gaps and periodic consumer stalls are mixed in, and the expected pooled values are recomputed arithmetically from the generated pixels.

// File: rtl/relu_pool_pkg.sv
package relu_pool_pkg;

  // strobes from the control to the datapath, one set per accepted pixel
  typedef struct packed {
    logic loadHold;   // capture into the per-lane hold register
    logic mergeLine;  // hold takes max(row store, pixel) instead of pixel
    logic writeLine;  // write the top-row pair maximum into the row store
    logic emit;       // bottom-right pixel of a window: result is final
  } poolStrobes_t;

endpackage

// File: rtl/relu_pool_ctrl.sv
module relu_pool_ctrl
  import relu_pool_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int MAX_H = 64,
  localparam int COL_W = $clog2(MAX_W + 1),
  localparam int ROW_W = $clog2(MAX_H + 1),
  localparam int IDX_W = $clog2(MAX_W / 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] frameWidth,
  input  logic [ROW_W-1:0] frameHeight,
  input  logic             inValid,
  input  logic             outValid,
  input  logic             outReady,
  output logic             inReady,
  output poolStrobes_t     strobes,
  output logic [IDX_W-1:0] slotIdx
);

  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic [COL_W-1:0] pairedW;
  logic [ROW_W-1:0] pairedH;
  logic             accept;
  logic             inWindow;
  logic             topRow;
  logic             leftCol;
  logic             lastCol;
  logic             lastRow;

  // the output slot is free or is being emptied this cycle
  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  // largest even extents: anything beyond is an unpaired edge
  assign pairedW = {frameWidth[COL_W-1:1], 1'b0};
  assign pairedH = {frameHeight[ROW_W-1:1], 1'b0};

  assign inWindow = (colCnt < pairedW) && (rowCnt < pairedH);
  assign topRow   = !rowCnt[0];
  assign leftCol  = !colCnt[0];
  assign lastCol  = (colCnt == frameWidth - COL_W'(1));
  assign lastRow  = (rowCnt == frameHeight - ROW_W'(1));
  assign slotIdx  = colCnt[IDX_W:1];

  always_comb begin
    strobes           = '0;
    if (accept && inWindow) begin
      strobes.loadHold  = leftCol;
      strobes.mergeLine = leftCol && !topRow;
      strobes.writeLine = !leftCol && topRow;
      strobes.emit      = !leftCol && !topRow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (accept) begin
      if (lastCol) begin
        colCnt <= '0;
        rowCnt <= lastRow ? '0 : rowCnt + ROW_W'(1);
      end else begin
        colCnt <= colCnt + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/relu_pool_lane.sv
module relu_pool_lane #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pixel,
  input  logic              loadHold,
  input  logic              mergeLine,
  input  logic              writeLine,
  input  logic [IDX_W-1:0]  slotIdx,
  output logic [DATA_W-1:0] pairMax
);

  logic [DATA_W-1:0] lineMem [SLOTS];
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] rectified;
  logic [DATA_W-1:0] lineVal;
  logic [DATA_W-1:0] colMax;

  // rectify: a set sign bit means negative, which becomes zero
  assign rectified = pixel[DATA_W-1] ? '0 : pixel;

  // every stored value is non-negative, so unsigned compare suffices
  assign lineVal = lineMem[slotIdx];
  assign colMax  = (lineVal > rectified) ? lineVal : rectified;
  assign pairMax = (hold > rectified) ? hold : rectified;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (loadHold) begin
      hold <= mergeLine ? colMax : rectified;
    end
  end

  always_ff @(posedge clk) begin
    if (writeLine) begin
      lineMem[slotIdx] <= pairMax;
    end
  end

endmodule

// File: rtl/relu_pool_outreg.sv
module relu_pool_outreg #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] loadData,
  input  logic             outReady,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (load) begin
      outValid <= 1'b1;
      outData  <= loadData;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/relu_maxpool2x2.sv
module relu_maxpool2x2
  import relu_pool_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CHANNELS = 4,
  parameter int MAX_W    = 64,
  parameter int MAX_H    = 64,
  localparam int COL_W  = $clog2(MAX_W + 1),
  localparam int ROW_W  = $clog2(MAX_H + 1),
  localparam int SLOTS  = MAX_W / 2,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int BUS_W  = CHANNELS * DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] frameWidth,
  input  logic [ROW_W-1:0] frameHeight,
  input  logic             inValid,
  output logic             inReady,
  input  logic [BUS_W-1:0] inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [BUS_W-1:0] outData
);

  poolStrobes_t     strobes;
  logic [IDX_W-1:0] slotIdx;
  logic [BUS_W-1:0] laneResult;

  relu_pool_ctrl #(
    .MAX_W(MAX_W),
    .MAX_H(MAX_H)
  ) ctrl (
    .clk        (clk),
    .rst        (rst),
    .frameWidth (frameWidth),
    .frameHeight(frameHeight),
    .inValid    (inValid),
    .outValid   (outValid),
    .outReady   (outReady),
    .inReady    (inReady),
    .strobes    (strobes),
    .slotIdx    (slotIdx)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    relu_pool_lane #(
      .DATA_W(DATA_W),
      .SLOTS (SLOTS)
    ) lane (
      .clk      (clk),
      .rst      (rst),
      .pixel    (inData[ch*DATA_W +: DATA_W]),
      .loadHold (strobes.loadHold),
      .mergeLine(strobes.mergeLine),
      .writeLine(strobes.writeLine),
      .slotIdx  (slotIdx),
      .pairMax  (laneResult[ch*DATA_W +: DATA_W])
    );
  end

  relu_pool_outreg #(
    .WIDTH(BUS_W)
  ) outStage (
    .clk     (clk),
    .rst     (rst),
    .load    (strobes.emit),
    .loadData(laneResult),
    .outReady(outReady),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: rtl/relu_maxpool2x2_checker.sv
module relu_maxpool2x2_checker #(
  parameter int DATA_W   = 16,
  parameter int CHANNELS = 4,
  localparam int BUS_W = CHANNELS * DATA_W
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [BUS_W-1:0] outData
);

  logic [33:0] inCount;
  logic [33:0] outCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      inCount  <= '0;
      outCount <= '0;
    end else begin
      if (inValid && inReady)   inCount  <= inCount + 34'd1;
      if (outValid && outReady) outCount <= outCount + 34'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_sign
    p_nonneg_r2: assert property (@(posedge clk) disable iff (rst)
      outValid |-> !outData[ch*DATA_W + DATA_W - 1]);
  end

  // every output consumes at least four accepted pixels
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (outCount << 2) <= inCount);

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData));

  p_stall_cause_r8: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> outValid && !outReady);

endmodule

bind relu_maxpool2x2 relu_maxpool2x2_checker #(
  .DATA_W  (DATA_W),
  .CHANNELS(CHANNELS)
) chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData)
);

// File: tb/relu_maxpool2x2_test.sv
module relu_maxpool2x2_test;

  localparam int DW = 16;
  localparam int CH = 4;
  localparam int MW = 16;
  localparam int MH = 16;
  localparam int CW = $clog2(MW + 1);
  localparam int RW = $clog2(MH + 1);
  localparam int BW = CH * DW;
  localparam int NF = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] frameWidth = '0;
  logic [RW-1:0] frameHeight = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [BW-1:0] inData = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [BW-1:0] outData;

  relu_maxpool2x2 #(
    .DATA_W(DW), .CHANNELS(CH), .MAX_W(MW), .MAX_H(MH)
  ) uut (
    .clk(clk), .rst(rst), .frameWidth(frameWidth), .frameHeight(frameHeight),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int pix [MH][MW][CH];
  logic [BW-1:0] expQ[$];
  int accQ[$];

  // frame plan: width, height, consumer stalls, input gaps, all-negative, tag
  int    fW  [NF] = '{4, 5, 4, 7, 8, 2, 16, 1, 6, 3};
  int    fH  [NF] = '{4, 4, 5, 7, 6, 2, 3, 3, 2, 2};
  bit    fBp [NF] = '{0, 0, 0, 1, 0, 0, 1, 0, 0, 1};
  bit    fGap[NF] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 1};
  bit    fNeg[NF] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
  string fReq[NF] = '{"R3", "R5", "R6", "R7", "R2", "R3", "R7", "R5", "R10", "R10"};

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int genVal(int f, int r, int c, int ch, bit neg);
    int v;
    v = (f * 53 + r * 29 + c * 17 + ch * 41 + r * c * 3) % 251 - 125;
    if (neg) v = -1 - ((v + 125) % 100);
    return v;
  endfunction

  task automatic buildFrame(int f);
    for (int r = 0; r < fH[f]; r++)
      for (int c = 0; c < fW[f]; c++)
        for (int ch = 0; ch < CH; ch++)
          pix[r][c][ch] = genVal(f, r, c, ch, fNeg[f]);
    for (int pr = 0; pr < fH[f] / 2; pr++)
      for (int pc = 0; pc < fW[f] / 2; pc++) begin
        logic [BW-1:0] word;
        word = '0;
        for (int ch = 0; ch < CH; ch++) begin
          int m;
          m = 0;
          for (int dr = 0; dr < 2; dr++)
            for (int dc = 0; dc < 2; dc++)
              if (pix[2*pr+dr][2*pc+dc][ch] > m) m = pix[2*pr+dr][2*pc+dc][ch];
          word[ch*DW +: DW] = DW'(m);
        end
        expQ.push_back(word);
      end
  endtask

  task automatic drive(int f);
    int stalls;
    stalls = 0;
    for (int r = 0; r < fH[f]; r++)
      for (int c = 0; c < fW[f]; c++) begin
        bit taken;
        taken = 0;
        while (!taken) begin
          @(negedge clk);
          inValid = !(fGap[f] && (cyc % 4 == 1));
          for (int ch = 0; ch < CH; ch++) inData[ch*DW +: DW] = DW'(pix[r][c][ch]);
          #1;
          if (inValid && !inReady) stalls++;
          if (inValid && inReady) begin
            taken = 1;
            if (r[0] && c[0] && r < (fH[f] / 2) * 2 && c < (fW[f] / 2) * 2)
              accQ.push_back(cyc + 1);
          end
        end
      end
    @(negedge clk);
    inValid = 1'b0;
    if (!fBp[f]) check(stalls == 0, "R8", "input stalls with consumer always ready", stalls, 0);
  endtask

  task automatic monitor(int f, int n);
    int got;
    bit pending;
    logic [BW-1:0] heldData;
    got = 0;
    pending = 0;
    heldData = '0;
    while (got < n) begin
      @(negedge clk);
      outReady = fBp[f] ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (pending) begin
        check(outValid == 1'b1, "R7", "valid dropped while stalled", outValid, 1);
        check(outData == heldData, "R7", "data changed while stalled", outData, heldData);
      end
      if (outValid && !pending) begin
        int a;
        a = (accQ.size() > 0) ? accQ.pop_front() : -1;
        check(a == cyc, "R9", "result cycle vs window completion", cyc, a);
      end
      if (outValid && outReady) begin
        logic [BW-1:0] e;
        e = (expQ.size() > 0) ? expQ.pop_front() : '0;
        check(outData == e, fReq[f], "pooled pixel", outData, e);
        got++;
      end
      pending  = outValid && !outReady;
      heldData = outData;
    end
    outReady = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    for (int f = 0; f < NF; f++) begin
      int n;
      frameWidth  = CW'(fW[f]);
      frameHeight = RW'(fH[f]);
      expQ.delete();
      accQ.delete();
      buildFrame(f);
      n = expQ.size();
      check(n == (fW[f] / 2) * (fH[f] / 2), "R4", "expected count setup", n,
            (fW[f] / 2) * (fH[f] / 2));
      fork
        drive(f);
        monitor(f, n);
      join
      repeat (4) begin
        @(negedge clk);
        #1;
        check(outValid == 1'b0, "R4", "extra output after frame", outValid, 0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule